// File: doc/BRIEF.md
# Progressive 480-Line Test Stream Generator with In-Band Sync

This block produces a progressive standard-definition video stream on a 16-bit 4:2:2 YCbCr bus, one word per 27 MHz sample clock. Horizontal and vertical timing travel inside the data as four-word timing reference codes: an end-of-active-video code opens every line and a start-of-active-video code closes its horizontal blanking. No separate sync or data-enable wires are used. Each line is 858 samples long: 138 samples of blanking followed by 720 active samples. Each frame is 525 lines long, and 480 of those lines carry picture content.

The picture is eight vertical colour bars of equal width. Blanking is filled with the black-level pair. Active samples are limited to the range 0x01..0xFE so that 0x00 and 0xFF appear only inside the timing codes. A downstream serializer or transmitter that decodes embedded sync can lock to the stream directly. An enable input holds the generator idle and drives black while it is low. Two debug outputs report the line and sample position of the word that is currently on the bus.

Top module: `esg_video_gen`

## Requirements
- R1: While reset is asserted, and directly after it, `vid_o` is 0x1080 (luma in bits 15:8 = 0x10, chroma in bits 7:0 = 0x80), and both debug counters read 0.
- R2: `vid_o` and the debug counters come from one register stage and always describe the same sample. While enabled, `dbg_sample_o` steps by one on each clock from 0 to LINE-1, where LINE = HBLANK + 8*BAR_W (858 by default), and then returns to 0. On that return `dbg_line_o` steps by one, and after line FRAME_LINES-1 it returns to 0.
- R3: Samples 0, 1 and 2 of every line carry 0xFF, 0x00 and 0x00 on both byte lanes. Sample 3 carries the flags word with H=1 on both lanes.
- R4: Samples HBLANK-4, HBLANK-3 and HBLANK-2 carry 0xFF, 0x00 and 0x00 on both lanes. Sample HBLANK-1 carries the flags word with H=0 on both lanes.
- R5: In the flags word, bit 7 is 1 and bit 6 is 0. Bit 5 is V, which is 1 on lines at or above ACTIVE_LINES. Bit 4 is H. Bits 3..0 are V^H, H, V and V^H. This gives 0x9D and 0x80 on picture lines, and 0xB6 and 0xAB on vertical-blanking lines.
- R6: All other horizontal-blanking samples carry luma 0x10 and chroma 0x80. Every sample from HBLANK upward on lines at or above ACTIVE_LINES carries the same pair.
- R7: On picture lines, sample HBLANK+k is in bar k/BAR_W. The bars' luma values, from bar 0 to bar 7, are B4, A2, 83, 70, 54, 41, 23 and 10 (hex).
- R8: On picture lines, chroma carries Cb when k is even and Cr when k is odd. The bar Cb values are 80, 2C, 9C, 48, B8, 64, D4, 80. The bar Cr values are 80, 8E, 2C, 3A, C6, D4, 72, 80.
- R9: No active-region sample on a picture line carries 0x00 or 0xFF on either lane.
- R10: When `en_i` is low at a clock edge, the next output is 0x1080 and both counters are 0. The first word after `en_i` returns high is line 0, sample 0 (0xFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run the stream; low forces black and rewinds the position |
| vid_o | output | 16 | Luma in bits 15:8, chroma in bits 7:0 |
| dbg_sample_o | output | SAMPLE_W (10) | Sample index of the word on `vid_o` |
| dbg_line_o | output | LINE_W (10) | Line index of the word on `vid_o` |

## Verification
The sample-counter wrap and the line-counter wrap fall on the same edge at the end of each frame. On that edge the V flag also changes, from 1 on the last blanking line to 0 for the first EAV of the next frame. The bench runs a reduced configuration through two whole frames and compares every word and both counters with values computed from the requirements, so the frame seam is checked twice. It then drops the enable exactly on the last sample of the frame, which makes the disable coincide with both wraps, and expects black at position zero and a clean restart from the first EAV word.

// File: rtl/esg_pkg.sv
package esg_pkg;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] c;
    } ycc_word_t;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } bar_colour_t;

    localparam logic [7:0] LUMA_BLACK  = 8'h10;
    localparam logic [7:0] CHROMA_ZERO = 8'h80;
    localparam logic [7:0] CODE_ONES   = 8'hFF;
    localparam logic [7:0] CODE_ZEROS  = 8'h00;
    localparam int unsigned TRS_LEN    = 4;
    localparam int unsigned BAR_COUNT  = 8;

    // Flags word of a timing reference code: marker, field, vertical, horizontal, protection.
    function automatic logic [7:0] trs_flags(input logic fld, input logic vb, input logic hb);
        return {1'b1, fld, vb, hb, vb ^ hb, fld ^ hb, fld ^ vb, fld ^ vb ^ hb};
    endfunction

    // Keep the two reserved code values out of picture samples.
    function automatic logic [7:0] clip_video(input logic [7:0] s);
        if (s == 8'h00) return 8'h01;
        if (s == 8'hFF) return 8'hFE;
        return s;
    endfunction

    function automatic bar_colour_t bar_colour(input logic [2:0] idx);
        case (idx)
            3'd0:    return '{y: 8'hB4, cb: 8'h80, cr: 8'h80};
            3'd1:    return '{y: 8'hA2, cb: 8'h2C, cr: 8'h8E};
            3'd2:    return '{y: 8'h83, cb: 8'h9C, cr: 8'h2C};
            3'd3:    return '{y: 8'h70, cb: 8'h48, cr: 8'h3A};
            3'd4:    return '{y: 8'h54, cb: 8'hB8, cr: 8'hC6};
            3'd5:    return '{y: 8'h41, cb: 8'h64, cr: 8'hD4};
            3'd6:    return '{y: 8'h23, cb: 8'hD4, cr: 8'h72};
            default: return '{y: 8'h10, cb: 8'h80, cr: 8'h80};
        endcase
    endfunction

endpackage

// File: rtl/esg_timing.sv
module esg_timing #(
    parameter int unsigned LINE_SAMPLES = 858,
    parameter int unsigned FRAME_LINES  = 525,
    localparam int unsigned SAMPLE_W    = $clog2(LINE_SAMPLES),
    localparam int unsigned LINE_W      = $clog2(FRAME_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic [LINE_W-1:0]   line_o
);

    localparam logic [SAMPLE_W-1:0] LAST_H = SAMPLE_W'(LINE_SAMPLES - 1);
    localparam logic [LINE_W-1:0]   LAST_V = LINE_W'(FRAME_LINES - 1);

    typedef struct packed {
        logic [SAMPLE_W-1:0] h;
        logic [LINE_W-1:0]   v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (!en_i) begin
            pos_d = '0;
        end else if (pos_q.h == LAST_H) begin
            pos_d.h = '0;
            pos_d.v = (pos_q.v == LAST_V) ? '0 : pos_q.v + 1'b1;
        end else begin
            pos_d.h = pos_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign sample_o = pos_q.h;
    assign line_o   = pos_q.v;

    p_sample_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.h <= LAST_H && pos_q.v <= LAST_V);

    p_sample_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && pos_q.h != LAST_H) |=> (pos_q.h == SAMPLE_W'($past(pos_q.h) + 1'b1)
                                         && $stable(pos_q.v)));

    p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && pos_q.h == LAST_H && pos_q.v == LAST_V) |=> (pos_q == '0));

    p_idle_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pos_q.h == '0 && pos_q.v == '0));

endmodule

// File: rtl/esg_bars.sv
module esg_bars
    import esg_pkg::*;
#(
    parameter int unsigned BAR_W    = 90,
    parameter int unsigned OFFSET_W = 10
) (
    input  logic [OFFSET_W-1:0] offset_i,
    output logic [7:0]          luma_o,
    output logic [7:0]          chroma_o
);

    logic [BAR_COUNT-2:0] beyond;
    logic [2:0]           bar_idx;
    bar_colour_t          colour;

    // One comparator per bar boundary; the bar index is the number passed.
    for (genvar g = 0; g < BAR_COUNT - 1; g++) begin : g_edge
        localparam logic [OFFSET_W-1:0] EDGE = OFFSET_W'((g + 1) * BAR_W);
        assign beyond[g] = (offset_i >= EDGE);
    end

    always_comb begin
        bar_idx = '0;
        for (int i = 0; i < BAR_COUNT - 1; i++) begin
            bar_idx = bar_idx + 3'(beyond[i]);
        end
        colour   = bar_colour(bar_idx);
        luma_o   = clip_video(colour.y);
        chroma_o = clip_video(offset_i[0] ? colour.cr : colour.cb);
    end

endmodule

// File: rtl/esg_video_gen.sv
module esg_video_gen
    import esg_pkg::*;
#(
    parameter int unsigned HBLANK       = 138,
    parameter int unsigned BAR_W        = 90,
    parameter int unsigned ACTIVE_LINES = 480,
    parameter int unsigned FRAME_LINES  = 525,
    localparam int unsigned LINE_SAMPLES = HBLANK + BAR_COUNT * BAR_W,
    localparam int unsigned SAMPLE_W     = $clog2(LINE_SAMPLES),
    localparam int unsigned LINE_W       = $clog2(FRAME_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    output logic [15:0]         vid_o,
    output logic [SAMPLE_W-1:0] dbg_sample_o,
    output logic [LINE_W-1:0]   dbg_line_o
);

    localparam logic [SAMPLE_W-1:0] EAV_END   = SAMPLE_W'(TRS_LEN);
    localparam logic [SAMPLE_W-1:0] SAV_START = SAMPLE_W'(HBLANK - TRS_LEN);
    localparam logic [SAMPLE_W-1:0] ACT_START = SAMPLE_W'(HBLANK);
    localparam logic [SAMPLE_W-1:0] EAV_FLAGS = SAMPLE_W'(TRS_LEN - 1);
    localparam logic [SAMPLE_W-1:0] SAV_FLAGS = SAMPLE_W'(HBLANK - 1);
    localparam logic [LINE_W-1:0]   VBL_START = LINE_W'(ACTIVE_LINES);
    localparam ycc_word_t           BLACK     = '{y: LUMA_BLACK, c: CHROMA_ZERO};

    typedef struct packed {
        logic                live;
        ycc_word_t           word;
        logic [SAMPLE_W-1:0] h;
        logic [LINE_W-1:0]   v;
    } out_t;

    logic [SAMPLE_W-1:0] sample;
    logic [LINE_W-1:0]   line;
    logic [SAMPLE_W-1:0] bar_off;
    logic [7:0]          bar_luma, bar_chroma;
    logic                vb, in_eav, in_sav;
    logic [1:0]          trs_pos;
    logic [7:0]          trs_byte;
    ycc_word_t           word;
    out_t                out_d, out_q;

    esg_timing #(
        .LINE_SAMPLES(LINE_SAMPLES),
        .FRAME_LINES (FRAME_LINES)
    ) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .sample_o(sample),
        .line_o  (line)
    );

    assign bar_off = sample - ACT_START;

    esg_bars #(
        .BAR_W   (BAR_W),
        .OFFSET_W(SAMPLE_W)
    ) u_bars (
        .offset_i(bar_off),
        .luma_o  (bar_luma),
        .chroma_o(bar_chroma)
    );

    always_comb begin
        vb      = (line >= VBL_START);
        in_eav  = (sample < EAV_END);
        in_sav  = (sample >= SAV_START) && (sample < ACT_START);
        trs_pos = in_eav ? sample[1:0] : 2'(sample - SAV_START);
        case (trs_pos)
            2'd0:    trs_byte = CODE_ONES;
            2'd3:    trs_byte = trs_flags(1'b0, vb, in_eav);
            default: trs_byte = CODE_ZEROS;
        endcase

        if (in_eav || in_sav)                 word = '{y: trs_byte, c: trs_byte};
        else if (sample >= ACT_START && !vb)  word = '{y: bar_luma, c: bar_chroma};
        else                                  word = BLACK;

        out_d.live = en_i;
        out_d.word = en_i ? word   : BLACK;
        out_d.h    = en_i ? sample : '0;
        out_d.v    = en_i ? line   : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{live: 1'b0, word: BLACK, h: '0, v: '0};
        else        out_q <= out_d;
    end

    assign vid_o        = out_q.word;
    assign dbg_sample_o = out_q.h;
    assign dbg_line_o   = out_q.v;

    p_code_lanes_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.live && (out_q.h < EAV_END || (out_q.h >= SAV_START && out_q.h < ACT_START)))
        |-> (vid_o[15:8] == vid_o[7:0]));

    p_eav_preamble_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.live && out_q.h == '0) |-> (vid_o == 16'hFFFF));

    p_flags_v_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.live && (out_q.h == EAV_FLAGS || out_q.h == SAV_FLAGS))
        |-> (vid_o[15] && !vid_o[14] && vid_o[13] == (out_q.v >= VBL_START)));

    p_vblank_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.live && out_q.v >= VBL_START && out_q.h >= ACT_START) |-> (vid_o == 16'h1080));

    p_no_reserved_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.live && out_q.v < VBL_START && out_q.h >= ACT_START)
        |-> (vid_o[15:8] != 8'h00 && vid_o[15:8] != 8'hFF && vid_o[7:0] != 8'h00 && vid_o[7:0] != 8'hFF));

    p_idle_black_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (vid_o == 16'h1080 && dbg_sample_o == '0 && dbg_line_o == '0));

endmodule

// File: tb/esg_video_gen_bench.sv
`timescale 1ns/1ps
module esg_video_gen_bench;

    localparam int HB = 10;
    localparam int BW = 3;
    localparam int AL = 4;
    localparam int FL = 7;
    localparam int L  = HB + 8 * BW;
    localparam int SW = $clog2(L);
    localparam int LW = $clog2(FL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [15:0]   vid;
    logic [SW-1:0] dbg_s;
    logic [LW-1:0] dbg_l;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    logic [7:0] t_y  [8] = '{8'hB4, 8'hA2, 8'h83, 8'h70, 8'h54, 8'h41, 8'h23, 8'h10};
    logic [7:0] t_cb [8] = '{8'h80, 8'h2C, 8'h9C, 8'h48, 8'hB8, 8'h64, 8'hD4, 8'h80};
    logic [7:0] t_cr [8] = '{8'h80, 8'h8E, 8'h2C, 8'h3A, 8'hC6, 8'hD4, 8'h72, 8'h80};

    always #4 clk = ~clk;

    esg_video_gen #(
        .HBLANK(HB), .BAR_W(BW), .ACTIVE_LINES(AL), .FRAME_LINES(FL)
    ) u_esg_video_gen (
        .clk(clk), .rst_n(rst_n), .en_i(en),
        .vid_o(vid), .dbg_sample_o(dbg_s), .dbg_line_o(dbg_l)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int h, input int v);
        bit         vb = (v >= AL);
        bit         hb;
        int         p, off;
        logic [7:0] b, y, c;
        if (h < 4 || (h >= HB - 4 && h < HB)) begin
            hb = (h < 4);
            p  = hb ? h : h - (HB - 4);
            if (p == 0)      b = 8'hFF;
            else if (p == 3) b = {1'b1, 1'b0, vb, hb, vb ^ hb, hb, vb, vb ^ hb};
            else             b = 8'h00;
            return {b, b};
        end
        if (h >= HB && !vb) begin
            off = h - HB;
            y = t_y[off / BW];
            c = (off % 2 == 0) ? t_cb[off / BW] : t_cr[off / BW];
            return {y, c};
        end
        return 16'h1080;
    endfunction

    task automatic check_pos(input int n);
        int          h = n % L;
        int          v = (n / L) % FL;
        logic [15:0] e = exp_word(h, v);
        string       ry, rc;
        bit          act = (h >= HB) && (v < AL);
        chk("R2", int'(dbg_s), h, "sample counter");
        chk("R2", int'(dbg_l), v, "line counter");
        if (h == 3 || h == HB - 1)     begin ry = "R5"; rc = "R5"; end
        else if (h < 4)                begin ry = "R3"; rc = "R3"; end
        else if (h >= HB - 4 && h < HB) begin ry = "R4"; rc = "R4"; end
        else if (act)                  begin ry = "R7"; rc = "R8"; end
        else                           begin ry = "R6"; rc = "R6"; end
        chk(ry, int'(vid[15:8]), int'(e[15:8]), $sformatf("luma line %0d sample %0d", v, h));
        chk(rc, int'(vid[7:0]),  int'(e[7:0]),  $sformatf("chroma line %0d sample %0d", v, h));
        if (act)
            chk("R9", int'(vid[15:8] == 8'h00 || vid[15:8] == 8'hFF ||
                           vid[7:0] == 8'h00 || vid[7:0] == 8'hFF), 0, "reserved value in picture");
    endtask

    task automatic run_span(input int count);
        for (int k = 0; k < count; k++) begin
            @(negedge clk);
            check_pos(k);
        end
    endtask

    task automatic check_idle(input string req, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            chk(req, int'(vid), 16'h1080, "idle word");
            chk(req, int'(dbg_s), 0, "idle sample counter");
            chk(req, int'(dbg_l), 0, "idle line counter");
        end
    endtask

    initial begin
        // R1: reset state
        check_idle("R1", 3);
        rst_n = 1'b1;
        // R10: enable still low after reset
        check_idle("R10", 2);

        // Two whole frames, every word compared (R2..R9), frame seam crossed twice
        en = 1'b1;
        run_span(2 * FL * L);

        // R10: disable on the frame's last sample, where both counters wrap
        en = 1'b0;
        check_idle("R10", 4);
        en = 1'b1;
        run_span(L + HB + 7);

        // R10: disable in the middle of the picture region
        en = 1'b0;
        check_idle("R10", 2);
        en = 1'b1;
        run_span(2 * L);

        // R1: reset mid-stream with enable held high, then restart from the origin
        @(negedge clk);
        rst_n = 1'b0;
        check_idle("R1", 2);
        rst_n = 1'b1;
        run_span(L);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule